// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block produces one interrupt line per port of a shared two-port memory. It watches the address and control signals each port drives into the memory array. Two words at the top of the address space act as mailboxes. The topmost word belongs to the right port. The word just below it belongs to the left port. The block never touches the data; the message itself lives in the memory.

A port posts a message by writing into the mailbox of its peer. That write pulls the peer's active-low interrupt line low. The owner of the mailbox acknowledges by reading its own mailbox, and that read releases its interrupt line high again. Reading the peer's mailbox is free of side effects.

Each port has a busy input that comes from the memory's contention arbiter. While a port's busy input is high, that port can neither post to its peer nor acknowledge its own interrupt. All decisions are made on the rising clock edge, and both interrupt outputs come straight from flops.

Top module: `mbx_irq_top`

## Requirements
- R1: After synchronous reset, both `l_int_n` and `r_int_n` are high (inactive).
- R2: A left-port write (`l_en`=1, `l_wr`=1) to address all-ones with `l_busy`=0 drives `r_int_n` low from the cycle after that clock edge.
- R3: A right-port write (`r_en`=1, `r_wr`=1) to address all-ones-minus-one with `r_busy`=0 drives `l_int_n` low from the cycle after that clock edge.
- R4: A port clears its own interrupt by reading its own mailbox: `en`=1, `wr`=0, `oe`=1 and `busy`=0. The right mailbox is at all-ones and the left mailbox is at all-ones-minus-one. The interrupt goes high from the next cycle.
- R5: A read by either port of the other port's mailbox changes neither interrupt.
- R6: While a port's `busy` is 1, its write to the peer mailbox leaves the peer's interrupt unchanged.
- R7: While a port's `busy` is 1, its read of its own mailbox leaves its own interrupt unchanged.
- R8: If a set and a clear of the same interrupt fall on the same clock edge, the interrupt ends low (the set wins).
- R9: None of the following sets or clears an interrupt: accesses with `en`=0, writes to any address other than the peer mailbox, writes to a port's own mailbox, and reads with `oe`=0.
- R10: With no qualifying set or clear, each interrupt holds its level indefinitely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_en | input | 1 | Left port memory select, active high |
| l_wr | input | 1 | Left port direction: 1 write, 0 read |
| l_oe | input | 1 | Left port output enable, active high |
| l_addr | input | AW | Left port word address |
| l_busy | input | 1 | Left port contention busy, active high |
| r_en | input | 1 | Right port memory select, active high |
| r_wr | input | 1 | Right port direction: 1 write, 0 read |
| r_oe | input | 1 | Right port output enable, active high |
| r_addr | input | AW | Right port word address |
| r_busy | input | 1 | Right port contention busy, active high |
| l_int_n | output | 1 | Left port interrupt, active low |
| r_int_n | output | 1 | Right port interrupt, active low |

## Verification
Each port posts into its peer's mailbox and then reads its own. This shows whether the two mailbox addresses are swapped and whether the set and clear paths go to the correct flag.

Cross reads, busy-gated accesses, writes to the poster's own mailbox or to the word just below both mailboxes, deselected cycles and reads without output enable are each run against a flag in a known state. Each of these patterns exposes a different missing qualifier in the decode.

A posting write and an acknowledging read are also issued on the same edge. This separates set-over-clear priority from the reverse order.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic {
    SIDE_L = 1'b0,
    SIDE_R = 1'b1
  } side_e;

  localparam int unsigned NUM_SIDES = 2;

  // returns the index of the opposite port
  function automatic int unsigned peer_of(input int unsigned idx);
    return (idx == 0) ? 1 : 0;
  endfunction

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import mbx_pkg::*;
#(
  parameter int unsigned AW   = 13,
  parameter side_e       SIDE = SIDE_L
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic          wr_i,
  input  logic          oe_i,
  input  logic [AW-1:0] addr_i,
  input  logic          busy_i,
  output logic          post_o,
  output logic          take_o
);

  localparam logic [AW-1:0] RIGHT_BOX = {AW{1'b1}};
  localparam logic [AW-1:0] LEFT_BOX  = {{(AW-1){1'b1}}, 1'b0};
  localparam logic [AW-1:0] OWN_BOX   = (SIDE == SIDE_R) ? RIGHT_BOX : LEFT_BOX;
  localparam logic [AW-1:0] PEER_BOX  = (SIDE == SIDE_R) ? LEFT_BOX  : RIGHT_BOX;

  logic hit_own;
  logic hit_peer;
  logic is_write;
  logic is_read;

  always_comb begin
    hit_own  = (addr_i == OWN_BOX);
    hit_peer = (addr_i == PEER_BOX);
    is_write = en_i && wr_i;
    is_read  = en_i && !wr_i && oe_i;
    post_o   = is_write && hit_peer && !busy_i;
    take_o   = is_read  && hit_own  && !busy_i;
  end

  // R6 / R7: a busy port produces no request of either kind
  a_r6_busy_no_post : assert property (@(posedge clk) disable iff (rst)
    busy_i |-> !post_o);
  a_r7_busy_no_take : assert property (@(posedge clk) disable iff (rst)
    busy_i |-> !take_o);

endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic int_n_o
);

  logic pending_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= 1'b0;
    end else if (set_i) begin
      pending_q <= 1'b1;
    end else if (clr_i) begin
      pending_q <= 1'b0;
    end
  end

  assign int_n_o = !pending_q;

  a_r8_set_wins : assert property (@(posedge clk) disable iff (rst)
    (set_i && clr_i) |=> !int_n_o);
  a_r10_hold : assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i) |=> $stable(int_n_o));

endmodule

// File: rtl/mbx_irq_top.sv
module mbx_irq_top
  import mbx_pkg::*;
#(
  parameter int unsigned AW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          l_en,
  input  logic          l_wr,
  input  logic          l_oe,
  input  logic [AW-1:0] l_addr,
  input  logic          l_busy,
  input  logic          r_en,
  input  logic          r_wr,
  input  logic          r_oe,
  input  logic [AW-1:0] r_addr,
  input  logic          r_busy,
  output logic          l_int_n,
  output logic          r_int_n
);

  localparam logic [AW-1:0] TOP_ADDR  = {AW{1'b1}};
  localparam logic [AW-1:0] NEXT_ADDR = {{(AW-1){1'b1}}, 1'b0};

  logic          en_a   [NUM_SIDES];
  logic          wr_a   [NUM_SIDES];
  logic          oe_a   [NUM_SIDES];
  logic [AW-1:0] addr_a [NUM_SIDES];
  logic          busy_a [NUM_SIDES];
  logic          post_a [NUM_SIDES];
  logic          take_a [NUM_SIDES];
  logic          intn_a [NUM_SIDES];

  assign en_a[0]   = l_en;
  assign wr_a[0]   = l_wr;
  assign oe_a[0]   = l_oe;
  assign addr_a[0] = l_addr;
  assign busy_a[0] = l_busy;
  assign en_a[1]   = r_en;
  assign wr_a[1]   = r_wr;
  assign oe_a[1]   = r_oe;
  assign addr_a[1] = r_addr;
  assign busy_a[1] = r_busy;

  for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
    localparam side_e THIS_SIDE = (g == 0) ? SIDE_L : SIDE_R;
    localparam int unsigned PEER = peer_of(g);

    mbx_port_decode #(
      .AW   (AW),
      .SIDE (THIS_SIDE)
    ) u_dec (
      .clk    (clk),
      .rst    (rst),
      .en_i   (en_a[g]),
      .wr_i   (wr_a[g]),
      .oe_i   (oe_a[g]),
      .addr_i (addr_a[g]),
      .busy_i (busy_a[g]),
      .post_o (post_a[g]),
      .take_o (take_a[g])
    );

    // the flag of this side is set by the peer's post, cleared by own take
    mbx_flag u_flag (
      .clk     (clk),
      .rst     (rst),
      .set_i   (post_a[PEER]),
      .clr_i   (take_a[g]),
      .int_n_o (intn_a[g])
    );
  end

  assign l_int_n = intn_a[0];
  assign r_int_n = intn_a[1];

  // port-level checks
  a_r2_left_posts_right : assert property (@(posedge clk) disable iff (rst)
    (l_en && l_wr && (l_addr == TOP_ADDR) && !l_busy) |=> !r_int_n);
  a_r3_right_posts_left : assert property (@(posedge clk) disable iff (rst)
    (r_en && r_wr && (r_addr == NEXT_ADDR) && !r_busy) |=> !l_int_n);
  a_r4_right_ack : assert property (@(posedge clk) disable iff (rst)
    (r_en && !r_wr && r_oe && (r_addr == TOP_ADDR) && !r_busy
     && !(l_en && l_wr && (l_addr == TOP_ADDR) && !l_busy)) |=> r_int_n);
  a_r6_left_busy_no_set : assert property (@(posedge clk) disable iff (rst)
    (r_int_n && l_busy) |=> r_int_n);
  a_r7_right_busy_keeps : assert property (@(posedge clk) disable iff (rst)
    (!r_int_n && r_busy) |=> !r_int_n);
  a_r5_right_only_own_read_clears : assert property (@(posedge clk) disable iff (rst)
    (!r_int_n && !(r_en && !r_wr && r_oe && (r_addr == TOP_ADDR))) |=> !r_int_n);
  a_r9_left_no_spurious_set : assert property (@(posedge clk) disable iff (rst)
    (l_int_n && !(r_en && r_wr && (r_addr == NEXT_ADDR))) |=> l_int_n);

endmodule

// File: tb/mbx_irq_top_bench.sv
`timescale 1ns/1ps
module mbx_irq_top_bench;

  localparam int unsigned AW = 13;
  localparam logic [AW-1:0] TOPA = {AW{1'b1}};
  localparam logic [AW-1:0] LBOX = TOPA - 1;

  logic clk = 1'b0;
  logic rst;
  logic l_en, l_wr, l_oe, l_busy, r_en, r_wr, r_oe, r_busy;
  logic [AW-1:0] l_addr, r_addr;
  logic l_int_n, r_int_n;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mbx_irq_top #(.AW(AW)) u_mbx_irq_top (
    .clk(clk), .rst(rst),
    .l_en(l_en), .l_wr(l_wr), .l_oe(l_oe), .l_addr(l_addr), .l_busy(l_busy),
    .r_en(r_en), .r_wr(r_wr), .r_oe(r_oe), .r_addr(r_addr), .r_busy(r_busy),
    .l_int_n(l_int_n), .r_int_n(r_int_n)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic idle();
    l_en = 0; l_wr = 0; l_oe = 0; l_busy = 0; l_addr = '0;
    r_en = 0; r_wr = 0; r_oe = 0; r_busy = 0; r_addr = '0;
  endtask

  // one-cycle access per side; returns at negedge after the capturing edge
  task automatic drive(input logic le, lw, lo, lb, input logic [AW-1:0] la,
                       input logic re, rw, ro, rb, input logic [AW-1:0] ra);
    @(negedge clk);
    l_en = le; l_wr = lw; l_oe = lo; l_busy = lb; l_addr = la;
    r_en = re; r_wr = rw; r_oe = ro; r_busy = rb; r_addr = ra;
    @(negedge clk);
    idle();
  endtask

  task automatic lacc(input logic e, w, o, b, input logic [AW-1:0] a);
    drive(e, w, o, b, a, 0, 0, 0, 0, '0);
  endtask

  task automatic racc(input logic e, w, o, b, input logic [AW-1:0] a);
    drive(0, 0, 0, 0, '0, e, w, o, b, a);
  endtask

  task automatic do_reset();
    idle();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 l_int_n", l_int_n, 1'b1);
    chk("R1 r_int_n", r_int_n, 1'b1);
  endtask

  task automatic t_left_post_right_ack();
    do_reset();
    lacc(1, 1, 0, 0, TOPA);
    chk("R2 r_int_n set", r_int_n, 1'b0);
    chk("R2 l_int_n untouched", l_int_n, 1'b1);
    racc(1, 0, 1, 0, TOPA);
    chk("R4 r_int_n cleared", r_int_n, 1'b1);
  endtask

  task automatic t_right_post_left_ack();
    do_reset();
    racc(1, 1, 0, 0, LBOX);
    chk("R3 l_int_n set", l_int_n, 1'b0);
    chk("R3 r_int_n untouched", r_int_n, 1'b1);
    lacc(1, 0, 1, 0, LBOX);
    chk("R4 l_int_n cleared", l_int_n, 1'b1);
  endtask

  task automatic t_cross_read();
    do_reset();
    lacc(1, 1, 0, 0, TOPA);
    racc(1, 1, 0, 0, LBOX);
    lacc(1, 0, 1, 0, TOPA);
    chk("R5 left reads right box, r_int_n", r_int_n, 1'b0);
    chk("R5 left reads right box, l_int_n", l_int_n, 1'b0);
    racc(1, 0, 1, 0, LBOX);
    chk("R5 right reads left box, l_int_n", l_int_n, 1'b0);
    chk("R5 right reads left box, r_int_n", r_int_n, 1'b0);
  endtask

  task automatic t_busy_set();
    do_reset();
    lacc(1, 1, 0, 1, TOPA);
    chk("R6 busy left post", r_int_n, 1'b1);
    racc(1, 1, 0, 1, LBOX);
    chk("R6 busy right post", l_int_n, 1'b1);
  endtask

  task automatic t_busy_clear();
    do_reset();
    lacc(1, 1, 0, 0, TOPA);
    racc(1, 1, 0, 0, LBOX);
    racc(1, 0, 1, 1, TOPA);
    chk("R7 busy right ack", r_int_n, 1'b0);
    lacc(1, 0, 1, 1, LBOX);
    chk("R7 busy left ack", l_int_n, 1'b0);
    racc(1, 0, 1, 0, TOPA);
    chk("R7 right ack after busy", r_int_n, 1'b1);
  endtask

  task automatic t_set_wins();
    do_reset();
    lacc(1, 1, 0, 0, TOPA);
    drive(1, 1, 0, 0, TOPA, 1, 0, 1, 0, TOPA);
    chk("R8 set over clear, right", r_int_n, 1'b0);
    do_reset();
    drive(1, 0, 1, 0, LBOX, 1, 1, 0, 0, LBOX);
    chk("R8 set over clear, left", l_int_n, 1'b0);
  endtask

  task automatic t_qualifiers();
    do_reset();
    lacc(0, 1, 0, 0, TOPA);
    chk("R9 deselected write", r_int_n, 1'b1);
    lacc(1, 1, 0, 0, TOPA - 2);
    chk("R9 write below boxes", r_int_n, 1'b1);
    lacc(1, 1, 0, 0, LBOX);
    chk("R9 left writes own box", l_int_n, 1'b1);
    racc(1, 1, 0, 0, '0);
    chk("R9 right writes address 0", l_int_n, 1'b1);
    lacc(1, 1, 0, 0, TOPA);
    racc(1, 0, 0, 0, TOPA);
    chk("R9 read without oe", r_int_n, 1'b0);
    racc(0, 0, 1, 0, TOPA);
    chk("R9 deselected read", r_int_n, 1'b0);
    racc(1, 1, 0, 0, TOPA);
    chk("R9 right writes own box", r_int_n, 1'b0);
  endtask

  task automatic t_hold();
    do_reset();
    lacc(1, 1, 0, 0, TOPA);
    racc(1, 1, 0, 0, LBOX);
    repeat (20) @(negedge clk);
    chk("R10 hold r_int_n", r_int_n, 1'b0);
    chk("R10 hold l_int_n", l_int_n, 1'b0);
  endtask

  initial begin
    rst = 1;
    idle();
    t_reset();
    t_left_post_right_ack();
    t_right_post_left_ack();
    t_cross_read();
    t_busy_set();
    t_busy_clear();
    t_set_wins();
    t_qualifiers();
    t_hold();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule